// File: doc/BRIEF.md
# SDRAM Host Request Adapter

This block connects a processor bus that behaves like static RAM to an SDRAM command sequencer. The host drops an active-low chip select together with one active-low strobe (read or write); the adapter registers the byte address, write data and transfer size, sends the sequencer exactly one single-cycle request, and pulls its active-low busy output down so the host holds its bus until the sequencer reports completion with a done pulse. One access is in flight at a time; there are no bursts.

From the registered size and the two lowest address bits the adapter forms active-low byte-lane masks. It also splits the word part of the address into bank, row and column fields. A write issued while the mode-select input is low does not touch memory. Instead it becomes a mode-register request, and the value to program travels on the low bits of the write data. A build parameter chooses how narrow read data is returned. It is either left in its natural byte lanes or moved down into the low-order lanes with the upper lanes zeroed.

Top module: `sdram_host_adapter`

## Requirements
- R1: While reset is applied and after it is released, host_busy_n is 1 and seq_rd_req, seq_wr_req and seq_mode_req are all 0.
- R2: When idle and armed, host_cs_n low with exactly one of host_rd_n/host_wr_n low is accepted at a clock edge. In the next cycle host_busy_n is 0 and exactly one request is 1 for one cycle only: seq_rd_req for a read, seq_wr_req for a write with host_mode_n high, and seq_mode_req for a write with host_mode_n low.
- R3: seq_done high in any cycle with host_busy_n low, including the request cycle itself, makes host_busy_n 1 in the next cycle. For a read, host_rdata carries the returned data in that same cycle and keeps it until the next read completes. seq_done while idle has no effect.
- R4: From the registered byte address: seq_bank = addr[22:21], seq_row = addr[20:10] and seq_col = addr[9:2]. These stay valid from the request cycle until completion.
- R5: seq_dqm_n has one active-low bit per byte lane, with bit i for data bits [8i+7:8i]. host_size 00 (and the unused code 11) gives 4'b0000. Size 01 (8-bit) clears only the bit at addr[1:0]. Size 10 (16-bit) gives 4'b1100 when addr[1] is 0 and 4'b0011 when it is 1.
- R6: A mode-register write raises seq_mode_req and never seq_wr_req. seq_wdata carries the host write data, and bits [10:0] hold the mode value. host_mode_n has no effect on reads.
- R7: Both host_rd_n and host_wr_n low together is ignored: host_busy_n stays 1 and no request is raised.
- R8: After an access is accepted, no new one is accepted until host_cs_n has been sampled high at least once. Holding chip select low after completion raises nothing.
- R9: With ALIGN_NARROW = 0, host_rdata is the returned word unchanged. With ALIGN_NARROW = 1, an 8-bit read returns the lane at addr[1:0] in bits [7:0] and a 16-bit read returns the half at addr[1] in bits [15:0]. The remaining bits are zero, and 32-bit reads are unchanged.
- R10: seq_wdata holds the write data registered at acceptance until the next access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_mode_n | input | 1 | Low during a write selects mode-register programming |
| host_size | input | 2 | 00 word, 01 byte, 10 half-word, 11 treated as word |
| host_addr | input | 23 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data returned to host |
| host_busy_n | output | 1 | Low while an access is in progress; host must hold its bus |
| seq_rd_req | output | 1 | Single-cycle read request |
| seq_wr_req | output | 1 | Single-cycle write request |
| seq_mode_req | output | 1 | Single-cycle mode-register request |
| seq_bank | output | 2 | Bank field |
| seq_row | output | 11 | Row field |
| seq_col | output | 8 | Column field |
| seq_dqm_n | output | 4 | Byte-lane masks, active low |
| seq_wdata | output | 32 | Registered write data; bits [10:0] are the mode value |
| seq_rdata | input | 32 | Read word from sequencer, valid with seq_done |
| seq_done | input | 1 | Single-cycle completion from sequencer |

## Verification
Two events can coincide: a request pulse going out and the completion coming back in the same cycle. A sequencer with zero latency answers during the request cycle itself. The bench provokes this by raising seq_done at the same sampling point where it observes the request. It then requires busy to rise one cycle later, with the correct read word, in both alignment variants. The other coincidence is completion with chip select still held low. That must release busy without also accepting a fresh access, and the bench judges it by holding chip select low for several cycles and watching for any request.

// File: rtl/sha_pkg.sv
package sha_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/sha_lane_mask.sv
module sha_lane_mask #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  sha_pkg::xfer_size_e size,
  input  logic [SEL_W-1:0]    offset,
  output logic [LANES-1:0]    mask_n
);
  import sha_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [SEL_W-1:0] LANE_IDX = SEL_W'(g);
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (offset == LANE_IDX);
        SZ_HALF: hit = (offset[SEL_W-1:1] == LANE_IDX[SEL_W-1:1]);
        default: hit = 1'b1;
      endcase
    end
    assign mask_n[g] = ~hit;
  end
endmodule

// File: rtl/sha_read_format.sv
module sha_read_format #(
  parameter int DATA_W       = 32,
  parameter bit ALIGN_NARROW = 1'b0,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  sha_pkg::xfer_size_e size,
  input  logic [SEL_W-1:0]    offset,
  input  logic [DATA_W-1:0]   word_in,
  output logic [DATA_W-1:0]   word_out
);
  import sha_pkg::*;

  if (ALIGN_NARROW) begin : g_align
    logic [SEL_W-1:0]  half_off;
    logic [DATA_W-1:0] byte_shift;
    logic [DATA_W-1:0] half_shift;
    assign half_off   = {offset[SEL_W-1:1], 1'b0};
    assign byte_shift = word_in >> {offset, 3'b000};
    assign half_shift = word_in >> {half_off, 3'b000};
    always_comb begin
      unique case (size)
        SZ_BYTE: word_out = {{(DATA_W-8){1'b0}}, byte_shift[7:0]};
        SZ_HALF: word_out = {{(DATA_W-16){1'b0}}, half_shift[15:0]};
        default: word_out = word_in;
      endcase
    end
  end else begin : g_natural
    logic unused_ok;
    assign unused_ok = ^{size, offset};
    assign word_out  = word_in;
  end
endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic mode_n,
  input  logic done,
  output logic busy_n,
  output logic rd_req,
  output logic wr_req,
  output logic mode_req,
  output logic capture,
  output logic rdata_load
);
  import sha_pkg::*;

  ctrl_state_e state_q, state_d;
  logic armed_q, armed_d;
  logic is_read_q, is_read_d;
  logic rd_req_d, wr_req_d, mode_req_d;
  logic finish;

  always_comb begin
    capture    = (state_q == ST_IDLE) && armed_q && !cs_n && (rd_n ^ wr_n);
    finish     = (state_q == ST_BUSY) && done;
    rdata_load = finish && is_read_q;

    state_d    = state_q;
    armed_d    = armed_q;
    is_read_d  = is_read_q;
    rd_req_d   = 1'b0;
    wr_req_d   = 1'b0;
    mode_req_d = 1'b0;

    if (cs_n) begin
      armed_d = 1'b1;
    end
    if (capture) begin
      state_d    = ST_BUSY;
      armed_d    = 1'b0;
      is_read_d  = !rd_n;
      rd_req_d   = !rd_n;
      wr_req_d   = !wr_n && mode_n;
      mode_req_d = !wr_n && !mode_n;
    end else if (finish) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      armed_q   <= 1'b0;
      is_read_q <= 1'b0;
      rd_req    <= 1'b0;
      wr_req    <= 1'b0;
      mode_req  <= 1'b0;
    end else begin
      state_q   <= state_d;
      armed_q   <= armed_d;
      is_read_q <= is_read_d;
      rd_req    <= rd_req_d;
      wr_req    <= wr_req_d;
      mode_req  <= mode_req_d;
    end
  end

  assign busy_n = (state_q == ST_IDLE);
endmodule

// File: rtl/sdram_host_adapter.sv
module sdram_host_adapter #(
  parameter int ADDR_W       = 23,
  parameter int DATA_W       = 32,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 11,
  parameter int COL_W        = 8,
  parameter bit ALIGN_NARROW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_mode_n,
  input  logic [1:0]        host_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_busy_n,
  output logic              seq_rd_req,
  output logic              seq_wr_req,
  output logic              seq_mode_req,
  output logic [BANK_W-1:0] seq_bank,
  output logic [ROW_W-1:0]  seq_row,
  output logic [COL_W-1:0]  seq_col,
  output logic [DATA_W/8-1:0] seq_dqm_n,
  output logic [DATA_W-1:0] seq_wdata,
  input  logic [DATA_W-1:0] seq_rdata,
  input  logic              seq_done
);
  import sha_pkg::*;

  localparam int LANES   = DATA_W / 8;
  localparam int SEL_W   = $clog2(LANES);
  localparam int COL_LSB = SEL_W;
  localparam int ROW_LSB = COL_LSB + COL_W;
  localparam int BNK_LSB = ROW_LSB + ROW_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic capture, rdata_load;

  sha_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_n       (host_cs_n),
    .rd_n       (host_rd_n),
    .wr_n       (host_wr_n),
    .mode_n     (host_mode_n),
    .done       (seq_done),
    .busy_n     (host_busy_n),
    .rd_req     (seq_rd_req),
    .wr_req     (seq_wr_req),
    .mode_req   (seq_mode_req),
    .capture    (capture),
    .rdata_load (rdata_load)
  );

  // request registers, loaded on acceptance
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  xfer_size_e        size_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= SZ_WORD;
    end else if (capture) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
      size_q  <= xfer_size_e'(host_size);
    end
  end

  sha_lane_mask #(.LANES(LANES)) u_mask (
    .size   (size_q),
    .offset (addr_q[SEL_W-1:0]),
    .mask_n (seq_dqm_n)
  );

  logic [DATA_W-1:0] rdata_fmt;
  sha_read_format #(.DATA_W(DATA_W), .ALIGN_NARROW(ALIGN_NARROW)) u_fmt (
    .size     (size_q),
    .offset   (addr_q[SEL_W-1:0]),
    .word_in  (seq_rdata),
    .word_out (rdata_fmt)
  );

  logic [DATA_W-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      rdata_q <= '0;
    else if (rdata_load) rdata_q <= rdata_fmt;
  end

  assign host_rdata = rdata_q;
  assign seq_wdata  = wdata_q;
  assign seq_col    = addr_q[COL_LSB +: COL_W];
  assign seq_row    = addr_q[ROW_LSB +: ROW_W];
  assign seq_bank   = addr_q[BNK_LSB +: BANK_W];
endmodule

// File: rtl/sdram_host_adapter_chk.sv
module sdram_host_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_cs_n,
  input logic       host_rd_n,
  input logic       host_wr_n,
  input logic       host_mode_n,
  input logic [1:0] host_size,
  input logic       host_busy_n,
  input logic       seq_rd_req,
  input logic       seq_wr_req,
  input logic       seq_mode_req,
  input logic [3:0] seq_dqm_n,
  input logic       seq_done
);
  logic any_req;
  assign any_req = seq_rd_req | seq_wr_req | seq_mode_req;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (host_busy_n && !any_req));

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_rd_req, seq_wr_req, seq_mode_req}));

  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  assert_busy_with_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_busy_n) |-> any_req);

  assert_done_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy_n && seq_done) |=> host_busy_n);

  assert_word_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && host_size == 2'b00) |-> (seq_dqm_n == 4'b0000));

  assert_mode_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy_n && !host_cs_n && host_rd_n && !host_wr_n && !host_mode_n)
      |=> !seq_wr_req);

  assert_both_strobes_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy_n && !host_rd_n && !host_wr_n) |=> (host_busy_n && !any_req));

  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_busy_n) && !host_cs_n && $past(!host_cs_n)) |=> host_busy_n);
endmodule

bind sdram_host_adapter sdram_host_adapter_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_cs_n    (host_cs_n),
  .host_rd_n    (host_rd_n),
  .host_wr_n    (host_wr_n),
  .host_mode_n  (host_mode_n),
  .host_size    (host_size),
  .host_busy_n  (host_busy_n),
  .seq_rd_req   (seq_rd_req),
  .seq_wr_req   (seq_wr_req),
  .seq_mode_req (seq_mode_req),
  .seq_dqm_n    (seq_dqm_n),
  .seq_done     (seq_done)
);

// File: tb/sdram_host_adapter_tb.sv
module sdram_host_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_cs_n, host_rd_n, host_wr_n, host_mode_n;
  logic [1:0]  host_size;
  logic [22:0] host_addr;
  logic [31:0] host_wdata, seq_rdata;
  logic        seq_done;

  logic [31:0] rdata, seq_wdata;
  logic        busy_n, rd_req, wr_req, mode_req;
  logic [1:0]  bank;
  logic [10:0] row;
  logic [7:0]  col;
  logic [3:0]  dqm_n;

  logic [31:0] a_rdata, a_wdata;
  logic        a_busy_n, a_rd, a_wr, a_mode;
  logic [1:0]  a_bank;
  logic [10:0] a_row;
  logic [7:0]  a_col;
  logic [3:0]  a_dqm;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_host_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_mode_n(host_mode_n), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata),
    .host_busy_n(busy_n), .seq_rd_req(rd_req), .seq_wr_req(wr_req),
    .seq_mode_req(mode_req), .seq_bank(bank), .seq_row(row), .seq_col(col),
    .seq_dqm_n(dqm_n), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
    .seq_done(seq_done));

  sdram_host_adapter #(.ALIGN_NARROW(1'b1)) dut_align_i (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_mode_n(host_mode_n), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(a_rdata),
    .host_busy_n(a_busy_n), .seq_rd_req(a_rd), .seq_wr_req(a_wr),
    .seq_mode_req(a_mode), .seq_bank(a_bank), .seq_row(a_row), .seq_col(a_col),
    .seq_dqm_n(a_dqm), .seq_wdata(a_wdata), .seq_rdata(seq_rdata),
    .seq_done(seq_done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic release_bus();
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_mode_n = 1'b1;
  endtask

  // {is_read, size, addr, expected dqm_n, expected aligned read data}
  localparam logic [61:0] VEC [8] = '{
    {1'b1, 2'b00, 23'h7ABCD0, 4'b0000, 32'hA1B2C3D4},
    {1'b1, 2'b01, 23'h2468A1, 4'b1101, 32'h000000C3},
    {1'b1, 2'b01, 23'h13579B, 4'b0111, 32'h000000A1},
    {1'b1, 2'b10, 23'h40000E, 4'b0011, 32'h0000A1B2},
    {1'b1, 2'b10, 23'h3FFFFC, 4'b1100, 32'h0000C3D4},
    {1'b0, 2'b01, 23'h0AAAA6, 4'b1011, 32'h00000000},
    {1'b0, 2'b00, 23'h555554, 4'b0000, 32'h00000000},
    {1'b1, 2'b11, 23'h600003, 4'b0000, 32'hA1B2C3D4}
  };
  localparam logic [31:0] RD_WORD = 32'hA1B2C3D4;

  // One access; call with the bus released and armed. Leaves chip select low
  // on return when hold is set.
  task automatic access(input bit is_rd, input bit mode_n, input logic [1:0] sz,
                        input logic [22:0] ad, input logic [31:0] wd, input int lat,
                        input bit hold, input logic [31:0] exp_nat,
                        input logic [31:0] exp_al, input bit chk_rdata);
    @(negedge clk);
    host_cs_n = 1'b0; host_rd_n = !is_rd; host_wr_n = is_rd; host_mode_n = mode_n;
    host_size = sz; host_addr = ad; host_wdata = wd;
    @(negedge clk);
    chk(busy_n == 1'b0, "R2 busy low after accept", 32'(busy_n), 32'd0);
    chk(rd_req == is_rd, "R2 read request", 32'(rd_req), 32'(is_rd));
    chk(wr_req == (!is_rd && mode_n), "R6 write request", 32'(wr_req), 32'(!is_rd && mode_n));
    chk(mode_req == (!is_rd && !mode_n), "R6 mode request", 32'(mode_req), 32'(!is_rd && !mode_n));
    chk(bank == ad[22:21], "R4 bank", 32'(bank), 32'(ad[22:21]));
    chk(row == ad[20:10], "R4 row", 32'(row), 32'(ad[20:10]));
    chk(col == ad[9:2], "R4 col", 32'(col), 32'(ad[9:2]));
    chk(seq_wdata == wd, "R10 write data", seq_wdata, wd);
    if (lat == 0) begin
      seq_done = 1'b1; seq_rdata = RD_WORD;
    end else begin
      @(negedge clk);
      chk(!rd_req && !wr_req && !mode_req, "R2 request single cycle",
          32'({rd_req, wr_req, mode_req}), 32'd0);
      chk(busy_n == 1'b0, "R3 busy held", 32'(busy_n), 32'd0);
      chk(row == ad[20:10], "R4 row held", 32'(row), 32'(ad[20:10]));
      for (int k = 1; k < lat; k++) @(negedge clk);
      seq_done = 1'b1; seq_rdata = RD_WORD;
    end
    @(negedge clk);
    seq_done = 1'b0; seq_rdata = 32'h0;
    chk(busy_n == 1'b1, "R3 busy released", 32'(busy_n), 32'd1);
    if (chk_rdata) begin
      chk(rdata == exp_nat, "R9 natural read data", rdata, exp_nat);
      chk(a_rdata == exp_al, "R9 aligned read data", a_rdata, exp_al);
    end
    if (!hold) release_bus();
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_nat, last_al;
    rst_n = 1'b0; release_bus(); host_size = 2'b00; host_addr = '0;
    host_wdata = '0; seq_rdata = '0; seq_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1 && !rd_req && !wr_req && !mode_req, "R1 reset state",
        32'({busy_n, rd_req, wr_req, mode_req}), 32'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_n == 1'b1 && !rd_req && !wr_req && !mode_req, "R1 after reset",
        32'({busy_n, rd_req, wr_req, mode_req}), 32'b1000);

    last_nat = 32'h0; last_al = 32'h0;
    for (int i = 0; i < 8; i++) begin
      logic [61:0] v;
      v = VEC[i];
      access(v[61], 1'b1, v[60:59], v[58:36], 32'hC0DE0000 + 32'(i), i % 3, 1'b1,
             RD_WORD, v[31:0], v[61]);
      if (v[61]) begin last_nat = RD_WORD; last_al = v[31:0]; end
      else begin
        chk(rdata == last_nat, "R3 read data held over write", rdata, last_nat);
        chk(a_rdata == last_al, "R3 aligned data held over write", a_rdata, last_al);
      end
      // mask checked at completion cycle (registered fields still valid)
      chk(dqm_n == v[35:32], "R5 byte masks", 32'(dqm_n), 32'(v[35:32]));
      release_bus();
    end

    // R8: chip select held low after completion raises nothing
    access(1'b1, 1'b1, 2'b00, 23'h012344, 32'h0, 2, 1'b1, RD_WORD, RD_WORD, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(busy_n && !rd_req && !wr_req, "R8 no re-accept while cs low",
          32'({busy_n, rd_req, wr_req}), 32'b100);
    end
    release_bus();

    // R6: mode-register write
    access(1'b0, 1'b0, 2'b00, 23'h000000, 32'h00000237, 1, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(seq_wdata[10:0] == 11'h237, "R6 mode value", 32'(seq_wdata[10:0]), 32'h237);
    // R6: mode select ignored on reads
    access(1'b1, 1'b0, 2'b00, 23'h100008, 32'h0, 1, 1'b0, RD_WORD, RD_WORD, 1'b1);

    // R7: both strobes low ignored
    @(negedge clk);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_wr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(busy_n && !rd_req && !wr_req && !mode_req, "R7 both strobes ignored",
          32'({busy_n, rd_req, wr_req, mode_req}), 32'b1000);
    end
    release_bus();

    // R3: done while idle has no effect
    @(negedge clk);
    seq_done = 1'b1; seq_rdata = 32'hDEADBEEF;
    @(negedge clk);
    seq_done = 1'b0;
    @(negedge clk);
    chk(busy_n == 1'b1, "R3 idle done ignored busy", 32'(busy_n), 32'd1);
    chk(rdata == RD_WORD, "R3 idle done ignored data", rdata, RD_WORD);

    // R3/R9: zero-latency byte read in both variants
    access(1'b1, 1'b1, 2'b01, 23'h7FFFFE, 32'h0, 0, 1'b0, RD_WORD, 32'h000000B2, 1'b1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule